// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the datapath half of a microcoded processor core. Every transfer between its storage elements crosses one shared 32-bit bus. An external sequencer supplies a word of control lines each cycle. At most one source places a value on the bus: the register file, the immediate extender, the ALU or the memory read data. Any number of destinations may capture the bus at the next rising clock edge: the instruction register, the two ALU operand latches, the memory address register and one register-file entry.

The register file holds 32 general registers and keeps the program counter as a 33rd entry. The entry is chosen by a select field, which names the rs, rt or rd field of the instruction register, the link register or the program counter. The block returns three values to the sequencer: the opcode of the held instruction, a flag that is high when operand latch A is zero, and the memory address. A slow memory whose access lasts several cycles sits outside the block. The sequencer waits on that memory's busy flag, so all of the block's pins are plain control and data lines with no handshake. Reset is asynchronous and active low.

Top module: `sbdp_bus_datapath`

## Requirements
- R1: After reset, the instruction register, both operand latches, the address register and every register-file entry are zero. So opcode is 0, a_zero is 1 and mem_addr is 0.
- R2: bus_out carries the value of whichever source is enabled (en_reg, en_imm, en_alu, en_mem). At most one enable may be high in a cycle. With none high, the bus reads zero.
- R3: reg_sel picks the register-file entry: 0 selects IR[25:21], 1 selects IR[20:16], 2 selects IR[15:11], 3 selects entry 31 and 4 selects entry 32, the program counter. With rf_we high, the bus value is written to that entry at the clock edge.
- R4: Entry 0 always reads as zero, and writes to it are dropped.
- R5: ld_ir, ld_a, ld_b and ld_ma each capture the bus at the clock edge. Without its load, a latch holds its value. opcode is IR[31:26] and mem_addr is the address register.
- R6: ext_mode selects the extender output from IR[15:0]: 0 sign-extends, 1 zero-extends, and 2 sign-extends and shifts left by two. Mode 3 zero-extends the 26-bit field IR[25:0].
- R7: alu_mode 0 yields A+4 and alu_mode 1 yields A+B.
- R8: alu_mode 2 applies the register function chosen by IR[2:0]: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed set-less-than, 6 shift A left by B[4:0], 7 shift A right logically by B[4:0].
- R9: alu_mode 3 yields the jump target {A[31:28], B[25:0], 2'b00}.
- R10: a_zero is high exactly when operand latch A holds zero.
- R11: With en_mem high, mem_rdata is placed on the bus. That is how instructions and load data enter the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 3 | Register-file entry select (rs, rt, rd, link, PC) |
| rf_we | input | 1 | Write bus into selected register-file entry |
| en_reg | input | 1 | Register file drives bus |
| en_imm | input | 1 | Immediate extender drives bus |
| en_alu | input | 1 | ALU drives bus |
| en_mem | input | 1 | Memory read data drives bus |
| ld_ir | input | 1 | Capture bus into instruction register |
| ld_a | input | 1 | Capture bus into operand latch A |
| ld_b | input | 1 | Capture bus into operand latch B |
| ld_ma | input | 1 | Capture bus into memory address register |
| ext_mode | input | 2 | Immediate extender mode |
| alu_mode | input | 2 | ALU operation class |
| mem_rdata | input | 32 | Read data from memory |
| opcode | output | 6 | IR[31:26] to the sequencer |
| a_zero | output | 1 | Operand latch A equals zero |
| mem_addr | output | 32 | Memory address register |
| bus_out | output | 32 | Shared bus value, also used as memory write data |

## Verification
The hardest situation to reach from the ports is one where a result depends on several earlier transfers at once. Examples are the register function chosen by bits of a held instruction, with operands that were themselves loaded over the bus from register entries named by other instruction fields. The stimulus reaches these by emulating the microprogram. It fetches an instruction word through memory into the instruction register and copies registers into A and B. It then swaps only the instruction word to walk all eight function codes on fixed operands. A full fetch sequence runs against a bench memory that holds busy for several cycles, and ends with the program counter stepped by four.

// File: rtl/sbdp_pkg.sv
`timescale 1ns/1ps
package sbdp_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    RSEL_RS   = 3'd0,
    RSEL_RT   = 3'd1,
    RSEL_RD   = 3'd2,
    RSEL_LINK = 3'd3,
    RSEL_PC   = 3'd4
  } rsel_e;

  typedef enum logic [1:0] {
    EXT_SEXT   = 2'd0,
    EXT_ZEXT   = 2'd1,
    EXT_SEXT_2 = 2'd2,
    EXT_JUMP   = 2'd3
  } ext_e;

  typedef enum logic [1:0] {
    ALU_INC4 = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_FUNC = 2'd2,
    ALU_JTGT = 2'd3
  } alu_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4,
    FN_SLT = 3'd5,
    FN_SLL = 3'd6,
    FN_SRL = 3'd7
  } fn_e;
endpackage

// File: rtl/sbdp_regfile.sv
`timescale 1ns/1ps
module sbdp_regfile #(
  parameter int W    = 32,
  parameter int NGPR = 32,
  localparam int NENT = NGPR + 1,
  localparam int IW   = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] st [1:NENT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NENT; i++) st[i] <= '0;
    end else if (we && idx != '0 && int'(idx) < NENT) begin
      st[idx] <= wdata;
    end
  end

  always_comb begin
    if (idx == '0 || int'(idx) >= NENT) rdata = '0;
    else                                rdata = st[idx];
  end

  // R3: a write lands in the addressed entry
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx != '0 && int'(idx) < NENT) |=> (st[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/sbdp_ext.sv
`timescale 1ns/1ps
module sbdp_ext
  import sbdp_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16,
  parameter int JW   = 26
) (
  input  logic [JW-1:0] fld,
  input  ext_e          mode,
  output logic [W-1:0]  y
);
  logic [IMMW-1:0] imm;
  logic [W-1:0]    sx;

  assign imm = fld[IMMW-1:0];
  assign sx  = {{(W-IMMW){imm[IMMW-1]}}, imm};

  always_comb begin
    unique case (mode)
      EXT_SEXT:   y = sx;
      EXT_ZEXT:   y = {{(W-IMMW){1'b0}}, imm};
      EXT_SEXT_2: y = {sx[W-3:0], 2'b00};
      default:    y = {{(W-JW){1'b0}}, fld};
    endcase
  end
endmodule

// File: rtl/sbdp_alu.sv
`timescale 1ns/1ps
module sbdp_alu
  import sbdp_pkg::*;
#(
  parameter int W  = 32,
  parameter int JW = 26,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_e         mode,
  input  fn_e          fn,
  output logic [W-1:0] y
);
  logic [W-1:0] fres;

  always_comb begin
    unique case (fn)
      FN_ADD:  fres = a + b;
      FN_SUB:  fres = a - b;
      FN_AND:  fres = a & b;
      FN_OR:   fres = a | b;
      FN_XOR:  fres = a ^ b;
      FN_SLT:  fres = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      FN_SLL:  fres = a << b[SHW-1:0];
      default: fres = a >> b[SHW-1:0];
    endcase
  end

  always_comb begin
    unique case (mode)
      ALU_INC4: y = a + W'(4);
      ALU_ADD:  y = a + b;
      ALU_FUNC: y = fres;
      default:  y = {a[W-1:JW+2], b[JW-1:0], 2'b00};
    endcase
  end
endmodule

// File: rtl/sbdp_bus_datapath.sv
`timescale 1ns/1ps
module sbdp_bus_datapath
  import sbdp_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int NGPR = 32,
  parameter int OPW  = 6,
  parameter int RFW  = 5,
  parameter int IMMW = 16,
  parameter int JW   = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          rf_we,
  input  logic          en_reg,
  input  logic          en_imm,
  input  logic          en_alu,
  input  logic          en_mem,
  input  logic          ld_ir,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_ma,
  input  logic [1:0]    ext_mode,
  input  logic [1:0]    alu_mode,
  input  logic [W-1:0]  mem_rdata,
  output logic [OPW-1:0] opcode,
  output logic          a_zero,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  bus_out
);
  localparam int NENT  = NGPR + 1;
  localparam int IW    = $clog2(NENT);
  localparam int RS_LO = W - OPW - RFW;
  localparam int RT_LO = RS_LO - RFW;
  localparam int RD_LO = RT_LO - RFW;
  localparam logic [IW-1:0] LINK_IDX = IW'(NGPR - 1);
  localparam logic [IW-1:0] PC_IDX   = IW'(NGPR);

  logic [W-1:0] ir_q, a_q, b_q, ma_q;
  logic [W-1:0] rf_rd, ext_y, alu_y, bus;
  logic [IW-1:0] rf_idx;

  always_comb begin
    unique case (rsel_e'(reg_sel))
      RSEL_RS:   rf_idx = IW'(ir_q[RS_LO +: RFW]);
      RSEL_RT:   rf_idx = IW'(ir_q[RT_LO +: RFW]);
      RSEL_RD:   rf_idx = IW'(ir_q[RD_LO +: RFW]);
      RSEL_LINK: rf_idx = LINK_IDX;
      RSEL_PC:   rf_idx = PC_IDX;
      default:   rf_idx = '0;
    endcase
  end

  sbdp_regfile #(.W(W), .NGPR(NGPR)) u_rf (
    .clk(clk), .rst_n(rst_n), .idx(rf_idx),
    .we(rf_we), .wdata(bus), .rdata(rf_rd)
  );

  sbdp_ext #(.W(W), .IMMW(IMMW), .JW(JW)) u_ext (
    .fld(ir_q[JW-1:0]), .mode(ext_e'(ext_mode)), .y(ext_y)
  );

  sbdp_alu #(.W(W), .JW(JW)) u_alu (
    .a(a_q), .b(b_q), .mode(alu_e'(alu_mode)),
    .fn(fn_e'(ir_q[2:0])), .y(alu_y)
  );

  // Shared bus: AND-OR of the source enables
  always_comb begin
    bus = ({W{en_reg}} & rf_rd) | ({W{en_imm}} & ext_y)
        | ({W{en_alu}} & alu_y) | ({W{en_mem}} & mem_rdata);
  end
  assign bus_out = bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir) ir_q <= bus;
      if (ld_a)  a_q  <= bus;
      if (ld_b)  b_q  <= bus;
      if (ld_ma) ma_q <= bus;
    end
  end

  assign opcode   = ir_q[W-1 -: OPW];
  assign a_zero   = (a_q == '0);
  assign mem_addr = ma_q;

  // R2: one bus driver at most
  p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({en_reg, en_imm, en_alu, en_mem}) <= 1);
  // R4: entry zero never reaches the bus as nonzero
  p_r0_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_reg && !en_imm && !en_alu && !en_mem && rf_idx == '0) |-> (bus_out == '0));
  // R5: address register follows the bus on load
  p_ma_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ma |=> (mem_addr == $past(bus_out)));
  // R5: opcode holds without an instruction load
  p_ir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ir |=> $stable(opcode));
  // R10: loading zero into A raises the flag
  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && bus_out == '0) |=> a_zero);
endmodule

// File: tb/sbdp_bus_datapath_test.sv
`timescale 1ns/1ps
module sbdp_bus_datapath_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_sel;
  logic rf_we, en_reg, en_imm, en_alu, en_mem, ld_ir, ld_a, ld_b, ld_ma;
  logic [1:0] ext_mode, alu_mode;
  logic [31:0] mem_rdata;
  logic [5:0] opcode;
  logic a_zero;
  logic [31:0] mem_addr, bus_out;

  always #2 clk = ~clk;

  sbdp_bus_datapath uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rf_we(rf_we),
    .en_reg(en_reg), .en_imm(en_imm), .en_alu(en_alu), .en_mem(en_mem),
    .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
    .ext_mode(ext_mode), .alu_mode(alu_mode), .mem_rdata(mem_rdata),
    .opcode(opcode), .a_zero(a_zero), .mem_addr(mem_addr), .bus_out(bus_out)
  );

  typedef struct { string tag; int kind; logic [31:0] exp; } item_t;
  item_t q[$];
  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] mem [16];

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
      input logic [4:0] rt, input logic [4:0] rd, input logic [10:0] lo);
    return {op, rs, rt, rd, lo};
  endfunction

  function automatic logic [31:0] ext_ref(input logic [31:0] ins, input int m);
    case (m)
      0: return {{16{ins[15]}}, ins[15:0]};
      1: return {16'h0, ins[15:0]};
      2: return {{14{ins[15]}}, ins[15:0], 2'b00};
      default: return {6'h0, ins[25:0]};
    endcase
  endfunction

  function automatic logic [31:0] fn_ref(input int f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      6: return a << b[4:0];
      default: return a >> b[4:0];
    endcase
  endfunction

  task automatic expect_v(input int kind, input logic [31:0] v, input string tag);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = v;
    q.push_back(it);
  endtask

  // Monitor: compares queued expectations mid-cycle
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      case (it.kind)
        0: got = bus_out;
        1: got = mem_addr;
        2: got = {26'h0, opcode};
        default: got = {31'h0, a_zero};
      endcase
      total++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s kind%0d: got %h expected %h", it.tag, it.kind, got, it.exp);
      end
    end
  end

  task automatic nxt();
    @(negedge clk);
    reg_sel = 3'd0; rf_we = 0; en_reg = 0; en_imm = 0; en_alu = 0; en_mem = 0;
    ld_ir = 0; ld_a = 0; ld_b = 0; ld_ma = 0; ext_mode = 2'd0; alu_mode = 2'd0;
    mem_rdata = 32'h0;
  endtask

  task automatic set_ir(input logic [31:0] ins);
    nxt(); mem_rdata = ins; en_mem = 1; ld_ir = 1;
    expect_v(0, ins, "R11 mem onto bus");
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] v);
    nxt(); mem_rdata = v; en_mem = 1; rf_we = 1; reg_sel = sel;
  endtask

  task automatic rd_chk(input logic [2:0] sel, input logic [31:0] v, input string tag);
    nxt(); en_reg = 1; reg_sel = sel;
    expect_v(0, v, tag);
  endtask

  logic [31:0] i1, i2, ifn, av, bv, pcv;

  initial begin
    nxt();
    repeat (3) nxt();
    rst_n = 1;
    // R1 reset state, R2 idle bus
    nxt();
    expect_v(0, 32'h0, "R2 idle bus zero");
    expect_v(2, 32'h0, "R1 opcode");
    expect_v(3, 32'h1, "R1 a_zero");
    expect_v(1, 32'h0, "R1 mem_addr");
    rd_chk(3'd4, 32'h0, "R1 pc entry");
    rd_chk(3'd3, 32'h0, "R1 link entry");

    i1 = mk(6'h23, 5'd5, 5'd9, 5'd17, 11'h405);
    set_ir(i1);
    nxt(); expect_v(2, 32'h23, "R5 opcode from IR");
    wr_reg(3'd0, 32'hDEADBEEF);
    wr_reg(3'd1, 32'h00000010);
    wr_reg(3'd2, 32'h12345678);
    wr_reg(3'd3, 32'hCAFEF00D);
    wr_reg(3'd4, 32'h00000008);
    rd_chk(3'd0, 32'hDEADBEEF, "R3 rs");
    rd_chk(3'd1, 32'h00000010, "R3 rt");
    rd_chk(3'd2, 32'h12345678, "R3 rd");
    rd_chk(3'd3, 32'hCAFEF00D, "R3 link");
    rd_chk(3'd4, 32'h00000008, "R3 pc");

    for (int m = 0; m < 4; m++) begin
      nxt(); en_imm = 1; ext_mode = 2'(m);
      expect_v(0, ext_ref(i1, m), "R6 extender negative imm");
    end
    i2 = mk(6'h0B, 5'd0, 5'd9, 5'd3, 11'h1C6);
    set_ir(i2);
    for (int m = 0; m < 4; m++) begin
      nxt(); en_imm = 1; ext_mode = 2'(m);
      expect_v(0, ext_ref(i2, m), "R6 extender positive imm");
    end
    // R4: write to entry 0 dropped
    wr_reg(3'd0, 32'hFFFFFFFF);
    rd_chk(3'd0, 32'h0, "R4 entry zero");

    set_ir(i1);
    nxt(); en_reg = 1; reg_sel = 3'd0; ld_a = 1;
    nxt(); en_reg = 1; reg_sel = 3'd1; ld_b = 1;
    expect_v(3, 32'h0, "R10 a_zero low");
    av = 32'hDEADBEEF; bv = 32'h00000010;
    nxt(); en_alu = 1; alu_mode = 2'd0;
    expect_v(0, av + 32'd4, "R7 inc4");
    nxt(); en_alu = 1; alu_mode = 2'd1; rf_we = 1; reg_sel = 3'd2;
    expect_v(0, av + bv, "R7 add");
    rd_chk(3'd2, av + bv, "R7 sum written to rd");

    for (int f = 0; f < 8; f++) begin
      ifn = mk(6'h00, 5'd5, 5'd9, 5'd17, 11'(f));
      set_ir(ifn);
      nxt(); en_alu = 1; alu_mode = 2'd2;
      expect_v(0, fn_ref(f, av, bv), "R8 function");
    end

    // R9 jump target
    nxt(); en_reg = 1; reg_sel = 3'd3; ld_a = 1;
    nxt(); en_imm = 1; ext_mode = 2'd3; ld_b = 1;
    nxt(); en_alu = 1; alu_mode = 2'd3;
    expect_v(0, {4'hC, ifn[25:0], 2'b00}, "R9 jump target");

    // R10 zero flag both ways
    nxt(); ld_a = 1;
    expect_v(0, 32'h0, "R2 no driver");
    nxt(); expect_v(3, 32'h1, "R10 a_zero high");
    en_reg = 1; reg_sel = 3'd2; ld_a = 1;
    nxt(); expect_v(3, 32'h0, "R10 a_zero after reload");
    // R5 address register
    en_alu = 1; alu_mode = 2'd0; ld_ma = 1;
    nxt(); expect_v(1, av + bv + 32'd4, "R5 mem_addr load");
    nxt(); expect_v(1, av + bv + 32'd4, "R5 mem_addr hold");

    // Fetch sequence against slow memory
    for (int k = 0; k < 16; k++) mem[k] = mk(6'(k + 16), 5'd1, 5'd2, 5'd3, 11'h0);
    pcv = 32'h8;
    nxt(); en_reg = 1; reg_sel = 3'd4; ld_ma = 1;
    expect_v(0, pcv, "R3 pc onto bus");
    nxt(); expect_v(1, pcv, "R5 fetch address");
    for (int busy = 3; busy > 0; busy--) nxt();
    mem_rdata = mem[mem_addr[5:2]]; en_mem = 1; ld_ir = 1;
    nxt(); expect_v(2, 32'd18, "R11 fetched opcode");
    en_reg = 1; reg_sel = 3'd4; ld_a = 1;
    nxt(); en_alu = 1; alu_mode = 2'd0; rf_we = 1; reg_sel = 3'd4;
    expect_v(0, pcv + 32'd4, "R7 pc step");
    rd_chk(3'd4, pcv + 32'd4, "R3 pc updated");
    nxt(); nxt();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule